// File: doc/BRIEF.md
# Misaligned-Capable Load/Store Unit

This block takes one memory request at a time from the memory stage of a 32-bit core and completes it against a word-wide RAM or a peripheral port. It handles byte, halfword and word accesses at any byte offset. When the bytes of an access fall in two adjacent RAM words, the unit issues two RAM beats, lower word first. It then joins the halves into one result, or spreads the store data over the two beats. A load result is widened to 32 bits with sign fill or zero fill, as the request selects.

Requests whose address lies in the peripheral window go to the MMIO port as a single beat. That port receives the full byte address, the size and the store data unshifted. A peripheral returns load data in its low bits, and the unit extends it in the same way as RAM data. The RAM reads synchronously: read data is valid in the cycle after the beat in which `ram_en` is high, and it holds until the next beat.

Top module: `lsu_unaligned`

## Requirements
- R1: An address A with 0x1000_0000 <= A < 0x1200_0000 produces exactly one `mmio_en` beat and no `ram_en` beat. Any other address uses RAM only, and `ram_en` and `mmio_en` are never high together.
- R2: `req_size`=0 selects a byte. A byte load returns the addressed byte in bits 7:0. Bits 31:8 copy bit 7 when `req_signed`=1 and are zero when `req_signed`=0.
- R3: `req_size`=1 selects a halfword. A halfword load returns the two bytes at A and A+1 in bits 15:0. Bits 31:16 are sign-filled from bit 15 when `req_signed`=1 and zero-filled when `req_signed`=0.
- R4: `req_size`=2 (and 3) selects a word. A word load returns the four bytes at A..A+3 unchanged, with `req_signed` having no effect.
- R5: Data is little-endian. The byte at offset k within a RAM word travels on bits 8k+7:8k and is enabled by `ram_be[k]`. A store enables only the bytes it covers, so every other RAM byte keeps its value.
- R6: An access whose last byte lies in the next RAM word takes two RAM beats, first to the word holding A and then to the word 4 bytes higher. An access held within one word takes a single beat.
- R7: A load that spans two words returns the same value as the same load read byte by byte (R2 to R4).
- R8: `req_ready` is high only while the unit is idle. `done` is a one-cycle pulse that is high 2 clock edges after acceptance for a single-beat access and 3 edges after acceptance for a split one. `rdata` is valid with `done` for loads and is zero for stores.
- R9: Every RAM beat carries a word-aligned address (`ram_addr[1:0]` = 0) and, on stores, a nonzero byte mask.
- R10: An MMIO access presents the original byte address, `req_size` and the unshifted `req_wdata`. The peripheral's read data is taken from its low bits and extended as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and accepting |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| done | output | 1 | Access complete (one cycle) |
| rdata | output | 32 | Extended load result |
| ram_en | output | 1 | RAM beat |
| ram_we | output | 1 | RAM beat writes |
| ram_addr | output | 32 | Word-aligned RAM address |
| ram_be | output | 4 | RAM byte enables |
| ram_wdata | output | 32 | Lane-steered store data |
| ram_rdata | input | 32 | RAM read data, one cycle after the beat |
| mmio_en | output | 1 | Peripheral beat |
| mmio_we | output | 1 | Peripheral write |
| mmio_addr | output | 32 | Peripheral byte address |
| mmio_size | output | 2 | Peripheral access size |
| mmio_wdata | output | 32 | Peripheral store data, unshifted |
| mmio_rdata | input | 32 | Peripheral read data, one cycle after the beat |

## Verification
On every cycle the assertions enforce the structural rules of the port side. RAM and MMIO are never selected together, and RAM beats are word-aligned with nonempty store masks. A second consecutive RAM beat addresses the next word, and `done` is a single pulse that follows a beat. Whether the split was needed, which lanes carry which bytes, and whether the extended result matches the addressed bytes can only be shown by the bench's scenarios. These compare against a byte-level model of the RAM at every offset and size, plus the window edges.

// File: rtl/lsu_unaligned.sv
module lsu_unaligned #(
  parameter logic [31:0] MMIO_BASE  = 32'h1000_0000,
  parameter logic [31:0] MMIO_LIMIT = 32'h1200_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        done,
  output logic [31:0] rdata,
  output logic        ram_en,
  output logic        ram_we,
  output logic [31:0] ram_addr,
  output logic [3:0]  ram_be,
  output logic [31:0] ram_wdata,
  input  logic [31:0] ram_rdata,
  output logic        mmio_en,
  output logic        mmio_we,
  output logic [31:0] mmio_addr,
  output logic [1:0]  mmio_size,
  output logic [31:0] mmio_wdata,
  input  logic [31:0] mmio_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_B0, S_B1, S_RSP} state_t;

  state_t      state;
  logic [31:0] a_q, wd_q, lo_q;
  logic [1:0]  sz_q;
  logic        sgn_q, we_q, mmio_q;

  logic [1:0]  off;
  logic [3:0]  szmask;
  logic [7:0]  mask8;
  logic        split;
  logic [63:0] wide, raw64;
  logic [31:0] sh, ext;

  assign off    = a_q[1:0];
  assign szmask = (sz_q == 2'd0) ? 4'b0001 : (sz_q == 2'd1) ? 4'b0011 : 4'b1111;
  assign mask8  = 8'({4'b0000, szmask} << off);
  assign split  = (|mask8[7:4]) && !mmio_q;
  assign wide   = {32'b0, wd_q} << {off, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      a_q    <= '0;
      wd_q   <= '0;
      lo_q   <= '0;
      sz_q   <= '0;
      sgn_q  <= 1'b0;
      we_q   <= 1'b0;
      mmio_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          a_q    <= req_addr;
          wd_q   <= req_wdata;
          sz_q   <= req_size;
          sgn_q  <= req_signed;
          we_q   <= req_write;
          mmio_q <= (req_addr >= MMIO_BASE) && (req_addr < MMIO_LIMIT);
          state  <= S_B0;
        end
        S_B0: state <= split ? S_B1 : S_RSP;
        S_B1: begin
          lo_q  <= ram_rdata;
          state <= S_RSP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);

  assign ram_en    = !mmio_q && (state == S_B0 || state == S_B1);
  assign ram_we    = ram_en && we_q;
  assign ram_addr  = (state == S_B1) ? {a_q[31:2] + 30'd1, 2'b00} : {a_q[31:2], 2'b00};
  assign ram_be    = (state == S_B1) ? mask8[7:4] : mask8[3:0];
  assign ram_wdata = (state == S_B1) ? wide[63:32] : wide[31:0];

  assign mmio_en    = mmio_q && (state == S_B0);
  assign mmio_we    = mmio_en && we_q;
  assign mmio_addr  = a_q;
  assign mmio_size  = sz_q;
  assign mmio_wdata = wd_q;

  assign raw64 = mmio_q ? {32'b0, mmio_rdata} : split ? {ram_rdata, lo_q} : {32'b0, ram_rdata};
  assign sh    = mmio_q ? raw64[31:0] : 32'(raw64 >> {off, 3'b000});

  always_comb begin
    case (sz_q)
      2'd0:    ext = {{24{sgn_q & sh[7]}}, sh[7:0]};
      2'd1:    ext = {{16{sgn_q & sh[15]}}, sh[15:0]};
      default: ext = sh;
    endcase
  end

  assign done  = (state == S_RSP);
  assign rdata = (done && !we_q) ? ext : 32'b0;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n) !(ram_en && mmio_en)); // R1
  AST_STORE_BE: assert property (@(posedge clk) disable iff (!rst_n) (ram_en && ram_we) |-> (ram_be != 4'b0000)); // R9
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) ram_en |-> (ram_addr[1:0] == 2'b00)); // R9
  AST_SECOND_BEAT_UP: assert property (@(posedge clk) disable iff (!rst_n) (ram_en && $past(ram_en)) |-> (ram_addr == $past(ram_addr) + 32'd4)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(ram_en || mmio_en) && !req_ready)); // R8

endmodule

// File: tb/lsu_unaligned_tb.sv
module lsu_unaligned_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, done, ram_en, ram_we, mmio_en, mmio_we;
  logic [31:0] rdata, ram_addr, ram_wdata, mmio_addr, mmio_wdata;
  logic [31:0] ram_rdata = '0, mmio_rdata = '0;
  logic [3:0]  ram_be;
  logic [1:0]  mmio_size;

  lsu_unaligned u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_signed(req_signed),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .mmio_en(mmio_en),
    .mmio_we(mmio_we), .mmio_addr(mmio_addr), .mmio_size(mmio_size),
    .mmio_wdata(mmio_wdata), .mmio_rdata(mmio_rdata)
  );

  logic [31:0] mem [16];
  logic [31:0] mmio_val = 32'h0000_00E5;
  logic [31:0] mw_addr, mw_data;
  logic [1:0]  mw_size;
  int          mw_count = 0;

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we)
        for (int k = 0; k < 4; k++)
          if (ram_be[k]) mem[ram_addr[5:2]][8*k +: 8] <= ram_wdata[8*k +: 8];
      ram_rdata <= mem[ram_addr[5:2]];
    end
    if (mmio_en) begin
      mmio_rdata <= mmio_val;
      if (mmio_we) begin
        mw_addr <= mmio_addr; mw_data <= mmio_wdata; mw_size <= mmio_size;
        mw_count <= mw_count + 1;
      end
    end
  end

  int ntests = 0, nfail = 0;
  int cyc, nbeats, nmmio;
  logic [31:0] res, a0, a1;

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(logic [31:0] a);
    return mem[a[5:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] exp_load(logic [31:0] a, logic [1:0] sz, logic sg);
    logic [31:0] v;
    v = {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
    if (sz == 2'd0) return {{24{sg & v[7]}}, v[7:0]};
    if (sz == 2'd1) return {{16{sg & v[15]}}, v[15:0]};
    return v;
  endfunction

  task automatic access(logic wr, logic [1:0] sz, logic sg, logic [31:0] a, logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; nbeats = 0; nmmio = 0; a0 = '0; a1 = '0; res = '0;
    forever begin
      if (ram_en) begin
        if (nbeats == 0) a0 = ram_addr; else a1 = ram_addr;
        nbeats++;
      end
      if (mmio_en) nmmio++;
      if (done) begin res = rdata; break; end
      if (cyc > 10) break;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic load_chk(string rq, logic [1:0] sz, logic sg, logic [31:0] a, int beats);
    logic [31:0] e;
    e = exp_load(a, sz, sg);
    access(1'b0, sz, sg, a, 32'h0);
    chk(rq, $sformatf("load sz%0d s%0d @%h", sz, sg, a), res, e);
    chk("R6", $sformatf("beats @%h", a), 32'(nbeats), 32'(beats));
    chk("R8", $sformatf("latency @%h", a), 32'(cyc), 32'(beats + 1));
    if (beats == 2) begin
      chk("R6", "first beat word", a0, {a[31:2], 2'b00});
      chk("R6", "second beat word", a1, {a[31:2], 2'b00} + 32'd4);
    end
  endtask

  task automatic store_chk(string rq, logic [1:0] sz, logic [31:0] a, logic [31:0] wd);
    logic [31:0] shadow [16];
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    foreach (mem[i]) shadow[i] = mem[i];
    for (int k = 0; k < n; k++) begin
      logic [31:0] b;
      b = a + 32'(k);
      shadow[b[5:2]][8*b[1:0] +: 8] = wd[8*k +: 8];
    end
    access(1'b1, sz, 1'b0, a, wd);
    chk("R8", "store rdata zero", res, 32'h0);
    chk("R6", $sformatf("store beats @%h", a), 32'(nbeats), ((a[1:0] + 32'(n)) > 4) ? 32'd2 : 32'd1);
    @(negedge clk);
    foreach (mem[i]) chk(rq, $sformatf("store @%h word %0d", a, i), mem[i], shadow[i]);
  endtask

  task automatic t_reset;
    chk("R8", "ready after reset", 32'(req_ready), 32'd1);
    chk("R8", "done after reset", 32'(done), 32'd0);
    chk("R1", "no beats after reset", 32'({ram_en, mmio_en}), 32'd0);
  endtask

  task automatic t_bytes;
    for (int o = 0; o < 4; o++) begin
      load_chk("R2", 2'd0, 1'b1, 32'h0000_0010 + 32'(o), 1);
      load_chk("R2", 2'd0, 1'b0, 32'h0000_0010 + 32'(o), 1);
    end
  endtask

  task automatic t_halves;
    load_chk("R3", 2'd1, 1'b1, 32'h0000_0020, 1);
    load_chk("R3", 2'd1, 1'b0, 32'h0000_0022, 1);
    load_chk("R3", 2'd1, 1'b1, 32'h0000_0021, 1);
    load_chk("R4", 2'd2, 1'b1, 32'h0000_0024, 1);
    load_chk("R4", 2'd3, 1'b0, 32'h0000_0028, 1);
  endtask

  task automatic t_split_loads;
    load_chk("R7", 2'd1, 1'b1, 32'h0000_0013, 2);
    load_chk("R7", 2'd1, 1'b0, 32'h0000_0017, 2);
    load_chk("R7", 2'd2, 1'b0, 32'h0000_0031, 2);
    load_chk("R7", 2'd2, 1'b1, 32'h0000_0032, 2);
    load_chk("R7", 2'd2, 1'b0, 32'h0000_0033, 2);
  endtask

  task automatic t_stores;
    store_chk("R5", 2'd0, 32'h0000_0006, 32'hFFFF_FF3C);
    store_chk("R5", 2'd1, 32'h0000_000A, 32'h1234_ABCD);
    store_chk("R5", 2'd1, 32'h0000_000F, 32'h0000_77E1);
    store_chk("R5", 2'd2, 32'h0000_0019, 32'hDEAD_BEEF);
    store_chk("R5", 2'd2, 32'h0000_0038, 32'h0BAD_F00D);
  endtask

  task automatic t_mmio;
    mmio_val = 32'h0000_00E5;
    access(1'b0, 2'd0, 1'b1, 32'h1000_0005, 32'h0);
    chk("R10", "mmio LB", res, 32'hFFFF_FFE5);
    chk("R1", "mmio beats", 32'({nmmio[7:0], nbeats[7:0]}), 32'h0100);
    access(1'b0, 2'd0, 1'b0, 32'h1000_0005, 32'h0);
    chk("R10", "mmio LBU", res, 32'h0000_00E5);
    mmio_val = 32'hCAFE_8001;
    access(1'b0, 2'd1, 1'b1, 32'h11FF_FFFF, 32'h0);
    chk("R10", "mmio LH top of window", res, 32'hFFFF_8001);
    chk("R1", "window top beats", 32'({nmmio[7:0], nbeats[7:0]}), 32'h0100);
    access(1'b1, 2'd1, 1'b0, 32'h1110_0000, 32'h0000_5555);
    chk("R10", "mmio store count", 32'(mw_count), 32'd1);
    chk("R10", "mmio store addr", mw_addr, 32'h1110_0000);
    chk("R10", "mmio store data", mw_data, 32'h0000_5555);
    chk("R10", "mmio store size", 32'(mw_size), 32'd1);
    chk("R1", "mmio store no ram", 32'(nbeats), 32'd0);
    access(1'b0, 2'd2, 1'b0, 32'h0FFF_FFFC, 32'h0);
    chk("R1", "below window to RAM", 32'({nmmio[7:0], nbeats[7:0]}), 32'h0001);
    chk("R4", "below window data", res, exp_load(32'h0FFF_FFFC, 2'd2, 1'b0));
    access(1'b0, 2'd2, 1'b0, 32'h1200_0000, 32'h0);
    chk("R1", "limit to RAM", 32'({nmmio[7:0], nbeats[7:0]}), 32'h0001);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    foreach (mem[i]) mem[i] = 32'h8F7E_A15C ^ (32'(i) * 32'h0113_2719);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_halves();
    t_split_loads();
    t_stores();
    t_mmio();
    finish_run();
  end
endmodule